// File: doc/BRIEF.md
# I2C Master-Read Termination Sequencer

This controller drives a double-buffered byte receiver through a master read of a given number of bytes. A start pulse loads the byte count. After the address phase has finished, the controller issues single-cycle commands to the receiver: acknowledge enable and disable, a flag that moves the NACK to the next byte, address-flag clear, stop request and data-register read. Each received byte is forwarded on a valid/data stream.

The NACK must land on exactly the last byte and the stop condition must go out at the right moment. For that, the command order depends on how many bytes remain: none, one, two, three, or more than three. A counter of remaining bytes counts down on every data-register read and chooses the branch. A wait for the address, data-ready or both-buffers-full flag that runs past a fixed limit aborts the transfer with an error pulse.

Top module: `i2c_rx_seq`

## Requirements
- R1: Out of reset the block is idle. `busy_o`, `done_o`, `err_o`, `byte_valid_o` and all six command outputs are low.
- R2: Count 0. Once `addr_flag_i` is seen, the block pulses `addr_clr_o`, then `stop_o` in the very next cycle, then `done_o`. It issues no data-register read.
- R3: Count 1. The commands come in consecutive cycles in this order: `ack_clr_o`, `addr_clr_o`, `stop_o`. The block then waits for `rxne_i` and pulses `dr_rd_o` once.
- R4: Count 2. The commands run `pos_set_o`, `addr_clr_o` and `ack_clr_o`, in consecutive cycles. The block then waits for `btf_i`, pulses `stop_o`, and then pulses `dr_rd_o` in two consecutive cycles.
- R5: Count above 2. The block pulses `ack_set_o` and then `addr_clr_o`. While more than three bytes remain, it issues one `dr_rd_o` per `rxne_i`.
- R6: With three bytes left, the block ignores `rxne_i` and waits for `btf_i`. It then pulses `ack_clr_o` and reads once. It waits for `btf_i` again, pulses `stop_o`, and reads twice in consecutive cycles. Any read with two bytes left happens only while `btf_i` is high.
- R7: The cycle after each `dr_rd_o` pulse, `byte_valid_o` is high for exactly one cycle. In that cycle `byte_o` equals the `rdata_i` value that was present during the read. Bytes appear in bus order.
- R8: `done_o` pulses for one cycle, after which the block is idle. For a nonzero count, `done_o` coincides with the strobe of the final byte.
- R9: The wait states are address, data-ready and both-full. If the awaited flag stays low for `TIMEOUT` consecutive cycles in any of them, `err_o` pulses once, the block returns to idle, and no further command is issued.
- R10: `start_i` has no effect while `busy_o` is high. The running transfer keeps its command sequence and byte count.
- R11: At most one of the six command outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| count_i | input | CNT_W | Number of bytes to read |
| addr_flag_i | input | 1 | Address phase complete |
| rxne_i | input | 1 | Data register holds a byte |
| btf_i | input | 1 | Data and shift registers both full |
| rdata_i | input | DATA_W | Data register contents |
| ack_set_o | output | 1 | Enable acknowledge |
| ack_clr_o | output | 1 | Disable acknowledge |
| pos_set_o | output | 1 | Apply NACK to the next byte instead of the current one |
| addr_clr_o | output | 1 | Clear the address flag |
| stop_o | output | 1 | Request stop condition |
| dr_rd_o | output | 1 | Read (pop) the data register |
| byte_valid_o | output | 1 | Received byte strobe |
| byte_o | output | DATA_W | Received byte |
| done_o | output | 1 | Transfer finished |
| err_o | output | 1 | Transfer aborted on timeout |
| busy_o | output | 1 | Transfer in progress |

## Verification
The assertions assume the receiver flags behave like a real double buffer. `rxne_i` stays high until the data register is read. `btf_i` is only high together with `rxne_i`. A read with a full shift register refills the data register on the same edge. The bench's receiver model works this way: it delivers bytes to the shift register at fixed spacing once the address flag is cleared, it holds the flags until a read pops them, and it raises the address flag only after a start. The timeout cases are reached by withholding the address flag or by stalling byte delivery. They do not come from flags that contradict each other.

// File: rtl/i2c_rx_seq_pkg.sv
package i2c_rx_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_WADDR, S_ACKSET, S_POS, S_ACKCLR, S_ADDRCLR,
    S_STOP, S_WRX, S_WBTF, S_RD, S_DONE, S_ERR
  } st_e;
endpackage

// File: rtl/i2c_rx_seq_rem.sv
module i2c_rx_seq_rem #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] rem_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_o <= '0;
    else if (load_i) rem_o <= val_i;
    else if (dec_i)  rem_o <= rem_o - CNT_W'(1);
  end
endmodule

// File: rtl/i2c_rx_seq_tmo.sv
module i2c_rx_seq_tmo #(
  parameter int TIMEOUT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  input  logic hit_i,
  output logic expired_o
);
  localparam int TW = $clog2(TIMEOUT + 1);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!wait_i || hit_i) cnt_q <= '0;
    else                      cnt_q <= cnt_q + TW'(1);
  end

  assign expired_o = wait_i && !hit_i && (cnt_q == TW'(TIMEOUT - 1));
endmodule

// File: rtl/i2c_rx_seq.sv
module i2c_rx_seq
  import i2c_rx_seq_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DATA_W  = 8,
  parameter int TIMEOUT = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              addr_flag_i,
  input  logic              rxne_i,
  input  logic              btf_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              ack_set_o,
  output logic              ack_clr_o,
  output logic              pos_set_o,
  output logic              addr_clr_o,
  output logic              stop_o,
  output logic              dr_rd_o,
  output logic              byte_valid_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              done_o,
  output logic              err_o,
  output logic              busy_o
);
  localparam logic [CNT_W-1:0] C1 = CNT_W'(1);
  localparam logic [CNT_W-1:0] C2 = CNT_W'(2);
  localparam logic [CNT_W-1:0] C3 = CNT_W'(3);

  st_e state_q, state_d;
  logic [CNT_W-1:0] rem;
  logic [CNT_W-1:0] rem_nx;
  logic load, waiting, hit, expired;

  assign load = (state_q == S_IDLE) && start_i;
  assign rem_nx = rem - C1;

  i2c_rx_seq_rem #(.CNT_W(CNT_W)) u_rem (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .val_i(count_i),
    .dec_i(dr_rd_o), .rem_o(rem)
  );

  always_comb begin
    waiting = 1'b0;
    hit     = 1'b0;
    unique case (state_q)
      S_WADDR: begin waiting = 1'b1; hit = addr_flag_i; end
      S_WRX:   begin waiting = 1'b1; hit = rxne_i;      end
      S_WBTF:  begin waiting = 1'b1; hit = btf_i;       end
      default: ;
    endcase
  end

  i2c_rx_seq_tmo #(.TIMEOUT(TIMEOUT)) u_tmo (
    .clk_i(clk_i), .rst_ni(rst_ni), .wait_i(waiting), .hit_i(hit),
    .expired_o(expired)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start_i) state_d = S_WADDR;
      S_WADDR:
        if (expired) state_d = S_ERR;
        else if (addr_flag_i) begin
          if (rem == '0)      state_d = S_ADDRCLR;
          else if (rem == C1) state_d = S_ACKCLR;  // NACK armed before address clear
          else if (rem == C2) state_d = S_POS;
          else                state_d = S_ACKSET;
        end
      S_ACKSET: state_d = S_ADDRCLR;
      S_POS:    state_d = S_ADDRCLR;
      S_ADDRCLR:
        if (rem <= C1)      state_d = S_STOP;      // stop right behind address clear
        else if (rem == C2) state_d = S_ACKCLR;
        else if (rem == C3) state_d = S_WBTF;
        else                state_d = S_WRX;
      S_ACKCLR:
        if (rem == C1)      state_d = S_ADDRCLR;
        else if (rem == C2) state_d = S_WBTF;
        else                state_d = S_RD;
      S_WBTF:
        if (expired)   state_d = S_ERR;
        else if (btf_i) state_d = (rem == C2) ? S_STOP : S_ACKCLR;
      S_STOP:
        if (rem == '0)      state_d = S_DONE;
        else if (rem == C1) state_d = S_WRX;
        else                state_d = S_RD;
      S_WRX:
        if (expired)     state_d = S_ERR;
        else if (rxne_i) state_d = S_RD;
      S_RD:
        if (rem_nx == '0)      state_d = S_DONE;
        else if (rem_nx == C1) state_d = S_RD;     // second read of the final pair
        else if (rem_nx <= C3) state_d = S_WBTF;
        else                   state_d = S_WRX;
      S_DONE:  state_d = S_IDLE;
      S_ERR:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign ack_set_o  = (state_q == S_ACKSET);
  assign ack_clr_o  = (state_q == S_ACKCLR);
  assign pos_set_o  = (state_q == S_POS);
  assign addr_clr_o = (state_q == S_ADDRCLR);
  assign stop_o     = (state_q == S_STOP);
  assign dr_rd_o    = (state_q == S_RD);
  assign done_o     = (state_q == S_DONE);
  assign err_o      = (state_q == S_ERR);
  assign busy_o     = (state_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_valid_o <= 1'b0;
      byte_o       <= '0;
    end else begin
      byte_valid_o <= dr_rd_o;
      if (dr_rd_o) byte_o <= rdata_i;
    end
  end
endmodule

// File: rtl/i2c_rx_seq_chk.sv
module i2c_rx_seq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [CNT_W-1:0] count_i,
  input logic             rxne_i,
  input logic             ack_set_o,
  input logic             ack_clr_o,
  input logic             pos_set_o,
  input logic             addr_clr_o,
  input logic             stop_o,
  input logic             dr_rd_o,
  input logic             byte_valid_o,
  input logic             done_o,
  input logic             err_o,
  input logic             busy_o
);
  logic [CNT_W-1:0] cap_q;
  logic [5:0] cmds;
  assign cmds = {ack_set_o, ack_clr_o, pos_set_o, addr_clr_o, stop_o, dr_rd_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cap_q <= '0;
    else if (start_i && !busy_o) cap_q <= count_i;
  end

  assert_one_cmd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmds));

  // R2 and R3: stop follows address clear directly for counts 0 and 1
  assert_stop_after_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_clr_o && cap_q <= CNT_W'(1)) |=> stop_o);

  assert_pos_then_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_set_o |=> addr_clr_o);

  assert_read_on_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_rd_o |-> rxne_i);

  assert_strobe_after_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_rd_o |=> byte_valid_o);

  assert_strobe_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> $past(dr_rd_o));

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  assert_err_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> (!busy_o && cmds == '0));
endmodule

bind i2c_rx_seq i2c_rx_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .count_i(count_i),
  .rxne_i(rxne_i), .ack_set_o(ack_set_o), .ack_clr_o(ack_clr_o),
  .pos_set_o(pos_set_o), .addr_clr_o(addr_clr_o), .stop_o(stop_o),
  .dr_rd_o(dr_rd_o), .byte_valid_o(byte_valid_o), .done_o(done_o),
  .err_o(err_o), .busy_o(busy_o)
);

// File: tb/sim_i2c_rx_seq.sv
module sim_i2c_rx_seq;
  localparam int CNT_W = 8;
  localparam int DATA_W = 8;
  localparam int TMO = 24;
  // event codes
  localparam int E_ACKSET = 1, E_ACKCLR = 2, E_POS = 3, E_ADDRCLR = 4,
                 E_STOP = 5, E_RD = 6, E_DONE = 7, E_ERR = 8, E_MULTI = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 1'b0;
  logic [CNT_W-1:0] count = '0;
  logic addr_f, dr_full, sh_full;
  logic [DATA_W-1:0] dr, sh;
  logic ack_set, ack_clr, pos_set, addr_clr, stop, dr_rd, bval, done, err, busy;
  logic [DATA_W-1:0] bdata;
  wire rxne = dr_full;
  wire btf = dr_full && sh_full;

  i2c_rx_seq #(.CNT_W(CNT_W), .DATA_W(DATA_W), .TIMEOUT(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .count_i(count),
    .addr_flag_i(addr_f), .rxne_i(rxne), .btf_i(btf), .rdata_i(dr),
    .ack_set_o(ack_set), .ack_clr_o(ack_clr), .pos_set_o(pos_set),
    .addr_clr_o(addr_clr), .stop_o(stop), .dr_rd_o(dr_rd),
    .byte_valid_o(bval), .byte_o(bdata), .done_o(done), .err_o(err), .busy_o(busy)
  );

  int total = 0, bad = 0;
  int exp_q[$];
  logic [DATA_W-1:0] byte_q[$];
  logic [DATA_W-1:0] bus_q[$];
  int cur_n = 0, rd_cnt = 0, prev_code = 0, tick = 0;
  bit addr_go = 0, bus_on = 0, stall = 0, mon_on = 0;
  bit done_seen = 0, err_seen = 0, finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // receiver model: double buffer, bytes arrive every third cycle after address clear
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_f <= 0; dr_full <= 0; sh_full <= 0; dr <= '0; sh <= '0;
      bus_on <= 0; tick <= 0;
    end else begin
      logic ndr, nsh;
      logic [DATA_W-1:0] vdr, vsh;
      ndr = dr_full; nsh = sh_full; vdr = dr; vsh = sh;
      if (dr_rd) ndr = 0;
      if (!ndr && nsh) begin vdr = vsh; ndr = 1; nsh = 0; end
      if (addr_go) addr_f <= 1;
      if (addr_clr) begin addr_f <= 0; bus_on <= 1; end
      if (start && !busy) bus_on <= 0;
      if (bus_on && !stall && bus_q.size() > 0 && !nsh) begin
        if (tick == 2) begin vsh = bus_q.pop_front(); nsh = 1; tick <= 0; end
        else tick <= tick + 1;
      end
      dr_full <= ndr; sh_full <= nsh; dr <= vdr; sh <= vsh;
    end
  end

  // per-cycle comparison against the expected event list
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      int code, n_on;
      n_on = int'(ack_set) + int'(ack_clr) + int'(pos_set) + int'(addr_clr) + int'(stop) + int'(dr_rd);
      code = 0;
      if (n_on > 1) code = E_MULTI;
      else if (ack_set) code = E_ACKSET;
      else if (ack_clr) code = E_ACKCLR;
      else if (pos_set) code = E_POS;
      else if (addr_clr) code = E_ADDRCLR;
      else if (stop) code = E_STOP;
      else if (dr_rd) code = E_RD;
      if (code == E_MULTI) chk(0, "R11 one command", n_on, 1);
      if (code != 0 && code != E_MULTI) begin
        chk(exp_q.size() > 0 && exp_q[0] == code, "R2-order command", code,
            exp_q.size() > 0 ? exp_q[0] : 0);
        if (exp_q.size() > 0) void'(exp_q.pop_front());
      end
      if (code == E_STOP && cur_n <= 1) chk(prev_code == E_ADDRCLR, "R3 stop adjacent", prev_code, E_ADDRCLR);
      if (prev_code == E_ADDRCLR && cur_n == 2) chk(code == E_ACKCLR, "R4 ackclr adjacent", code, E_ACKCLR);
      if (prev_code == E_POS) chk(code == E_ADDRCLR, "R4 pos then clr", code, E_ADDRCLR);
      if (code == E_RD) begin
        chk(rxne, "R5 read needs rxne", rxne, 1);
        if (cur_n - rd_cnt <= 3 && cur_n >= 3 && cur_n - rd_cnt >= 2) chk(btf, "R6 read needs btf", btf, 1);
        if (cur_n == 2 && rd_cnt == 0) chk(btf, "R4 read needs btf", btf, 1);
        rd_cnt++;
      end
      if (bval) begin
        chk(byte_q.size() > 0 && byte_q[0] == bdata, "R7 byte order", bdata,
            byte_q.size() > 0 ? byte_q[0] : -1);
        if (byte_q.size() > 0) void'(byte_q.pop_front());
      end
      if (done) begin
        chk(exp_q.size() > 0 && exp_q[0] == E_DONE, "R8 done placement", E_DONE,
            exp_q.size() > 0 ? exp_q[0] : 0);
        if (exp_q.size() > 0) void'(exp_q.pop_front());
        chk(bval == (cur_n > 0), "R8 done with last strobe", bval, cur_n > 0);
        done_seen = 1;
      end
      if (err) begin
        chk(exp_q.size() > 0 && exp_q[0] == E_ERR, "R9 error", E_ERR,
            exp_q.size() > 0 ? exp_q[0] : 0);
        if (exp_q.size() > 0) void'(exp_q.pop_front());
        err_seen = 1;
      end
      prev_code = code;
    end
  end

  task automatic run_xfer(input int n, input bit no_addr, input bit do_stall, input bit restart);
    exp_q.delete(); byte_q.delete(); bus_q.delete();
    cur_n = n; rd_cnt = 0; done_seen = 0; err_seen = 0; stall = do_stall;
    if (no_addr) exp_q.push_back(E_ERR);
    else if (n == 0) exp_q = '{E_ADDRCLR, E_STOP, E_DONE};
    else if (n == 1) exp_q = '{E_ACKCLR, E_ADDRCLR, E_STOP, E_RD, E_DONE};
    else if (n == 2) exp_q = '{E_POS, E_ADDRCLR, E_ACKCLR, E_STOP, E_RD, E_RD, E_DONE};
    else begin
      exp_q = '{E_ACKSET, E_ADDRCLR};
      if (do_stall) exp_q.push_back(E_ERR);
      else begin
        for (int i = 0; i < n - 3; i++) exp_q.push_back(E_RD);
        exp_q.push_back(E_ACKCLR); exp_q.push_back(E_RD); exp_q.push_back(E_STOP);
        exp_q.push_back(E_RD); exp_q.push_back(E_RD); exp_q.push_back(E_DONE);
      end
    end
    for (int i = 0; i < n; i++) begin
      logic [DATA_W-1:0] v;
      v = DATA_W'((n * 17 + i * 29 + 5) & 8'hff);
      bus_q.push_back(v);
      if (!do_stall && !no_addr) byte_q.push_back(v);
    end
    @(negedge clk); start = 1; count = CNT_W'(n);
    @(negedge clk); start = 0; count = CNT_W'(7);
    if (restart) begin start = 1; @(negedge clk); start = 0; end  // R10 ignored restart
    repeat (2) @(negedge clk);
    if (!no_addr) begin addr_go = 1; @(negedge clk); addr_go = 0; end
    for (int c = 0; c < 2000 && !done_seen && !err_seen; c++) @(negedge clk);
    chk(done_seen || err_seen, "R8 transfer ended", 0, 1);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, restart ? "R10 sequence intact" : "R5 events consumed", exp_q.size(), 0);
    chk(byte_q.size() == 0, "R7 all bytes out", byte_q.size(), 0);
    chk(!busy, no_addr || do_stall ? "R9 idle after error" : "R8 idle after done", busy, 0);
    stall = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !bval, "R1 reset idle", busy, 0);
    chk({ack_set, ack_clr, pos_set, addr_clr, stop, dr_rd} == 6'b0, "R1 no commands", 1, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy, "R1 idle after release", busy, 0);
    mon_on = 1;
    run_xfer(0, 0, 0, 0);  // R2
    run_xfer(1, 0, 0, 0);  // R3
    run_xfer(2, 0, 0, 0);  // R4
    run_xfer(3, 0, 0, 0);  // R6
    run_xfer(4, 0, 0, 0);  // R5
    run_xfer(9, 0, 0, 0);  // R5 R6
    run_xfer(5, 0, 0, 1);  // R10
    run_xfer(2, 1, 0, 0);  // R9 address wait
    run_xfer(6, 0, 1, 0);  // R9 data wait
    run_xfer(1, 0, 0, 0);  // recovery after error
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule